// File: doc/BRIEF.md
# Parallel Signature ROM Self-Test Engine

This block runs a built-in self-test of an embedded ROM whose read port returns a 32-bit word per access. A single enable input starts the test. From then on the engine sequences the ROM addresses on its own and compacts every returned word into a 32-bit multiple-input signature register. It absorbs one full word per clock, with no serialising buffer. When the last word has been absorbed, the engine compares the signature with a golden constant that is fixed at build time. It then raises a done flag and a single pass/fail pin.

The ROM is assumed to be synchronous, with one cycle of read latency. The signature register also serves as a test data register. While the engine is idle or finished, a shift strobe moves it one bit toward its LSB per clock. The LSB is presented on a serial output and a serial input fills the MSB, so an external test-access controller can read the signature or overwrite it. Dropping the enable abandons any run and returns the engine to idle.

Top module: `rom_sig_bist`

## Requirements
- R1: After reset, done_o, pass_o and rom_rd_o are 0.
- R2: During a run, rom_rd_o is high for exactly DEPTH = 2**ADDR_W consecutive cycles, and rom_addr_o presents 0, 1, ..., DEPTH-1 in those cycles, in that order.
- R3: The signature starts from all ones at every run start. For each ROM word d it becomes {s[30:0],1'b0} ^ (s[31] ? 32'h0040_0007 : 0) ^ d, which is the polynomial x^32+x^22+x^2+x+1.
- R4: done_o goes high at the (DEPTH+3)th rising edge, counting the edge that first samples test_en_i high in idle as the first. It stays high while test_en_i stays high.
- R5: When done_o is high, pass_o is 1 if the final signature equals GOLDEN_SIG and 0 otherwise.
- R6: pass_o is 0 whenever done_o is 0.
- R7: When test_en_i is low at a rising edge, the engine is idle after that edge: rom_rd_o=0 and done_o=0. A later enable restarts the run from address 0.
- R8: When tdr_shift_i is high in idle or done, each edge shifts the signature right by one bit, with tdr_si_i entering bit 31. tdr_so_o always shows bit 0. done_o and pass_o are unchanged.
- R9: tdr_shift_i has no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_en_i | input | 1 | Test enable; high starts a run, low aborts the run and idles the engine |
| rom_addr_o | output | ADDR_W | ROM read address |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_data_i | input | 32 | ROM read data, valid one cycle after the strobe |
| tdr_shift_i | input | 1 | Serial shift strobe for the signature register |
| tdr_si_i | input | 1 | Serial data into the signature MSB |
| tdr_so_o | output | 1 | Signature LSB |
| done_o | output | 1 | Test complete |
| pass_o | output | 1 | Test result, valid while done_o is high |

## Verification
After the enabling edge, the address strobe rises one edge later. A word read at edge k is absorbed at edge k+1. The compare and the done flag land two edges after the last read, which is the (DEPTH+3)th edge in all. The bench drives inputs on falling edges and counts falling edges until done_o rises, so that count must be exactly DEPTH+3, and it checks the address stream at every falling edge while the strobe is high. Serial readout is sampled on the falling edge before each shifting rising edge, so bit i of the signature is seen at step i. An abort is checked on the falling edge right after the edge that samples the low enable.

// File: rtl/rom_sig_pkg.sv
package rom_sig_pkg;
  localparam int unsigned SIG_W = 32;
  localparam logic [SIG_W-1:0] SIG_TAPS = 32'h0040_0007; // x^22 + x^2 + x + 1
  localparam logic [SIG_W-1:0] SIG_SEED = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_DRAIN,
    ST_CMP,
    ST_DONE
  } bist_state_e;
endpackage

// File: rtl/rom_sig_seq.sv
module rom_sig_seq
  import rom_sig_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              tdr_shift_i,
  input  logic              match_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_rd_o,
  output logic              seed_o,
  output logic              absorb_o,
  output logic              shift_ok_o,
  output logic              done_o,
  output logic              pass_o
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  bist_state_e       st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q, done_q, pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (!test_en_i) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q   <= ST_READ;
          addr_q <= '0;
        end
        ST_READ: begin
          vld_q <= 1'b1;
          if (addr_q == LAST_ADDR) st_q <= ST_DRAIN;
          else addr_q <= addr_q + 1'b1;
        end
        ST_DRAIN: begin
          vld_q <= 1'b0; // last word absorbed at this edge
          st_q  <= ST_CMP;
        end
        ST_CMP: begin
          done_q <= 1'b1;
          pass_q <= match_i;
          st_q   <= ST_DONE;
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end

  assign rom_addr_o = addr_q;
  assign rom_rd_o   = (st_q == ST_READ);
  assign seed_o     = test_en_i && (st_q == ST_IDLE);
  assign absorb_o   = vld_q;
  assign shift_ok_o = tdr_shift_i && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign done_o     = done_q;
  assign pass_o     = pass_q;

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_rd_o && $past(rom_rd_o) |-> rom_addr_o == $past(rom_addr_o) + 1'b1);
  // R4
  done_after_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(st_q) == ST_CMP);
  // R6
  pass_only_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !pass_o);
  // R7
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> !rom_rd_o && !done_o);
endmodule

// File: rtl/rom_sig_misr.sv
module rom_sig_misr
  import rom_sig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_i,
  input  logic             absorb_i,
  input  logic [SIG_W-1:0] data_i,
  input  logic             shift_i,
  input  logic             si_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             so_o
);
  logic [SIG_W-1:0] sig_q, step;

  always_comb begin
    step = {sig_q[SIG_W-2:0], 1'b0} ^ data_i;
    if (sig_q[SIG_W-1]) step = step ^ SIG_TAPS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sig_q <= SIG_SEED;
    else if (seed_i)   sig_q <= SIG_SEED;
    else if (absorb_i) sig_q <= step;
    else if (shift_i)  sig_q <= {si_i, sig_q[SIG_W-1:1]};
  end

  assign sig_o = sig_q;
  assign so_o  = sig_q[0];

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_i && !absorb_i && !shift_i |=> $stable(sig_q));
  // R3
  seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> sig_q == SIG_SEED);
endmodule

// File: rtl/rom_sig_bist.sv
module rom_sig_bist
  import rom_sig_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 6,
  parameter logic [31:0]      GOLDEN_SIG = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_rd_o,
  input  logic [31:0]       rom_data_i,
  input  logic              tdr_shift_i,
  input  logic              tdr_si_i,
  output logic              tdr_so_o,
  output logic              done_o,
  output logic              pass_o
);
  logic             seed, absorb, shift_ok;
  logic [SIG_W-1:0] sig;

  rom_sig_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_en_i  (test_en_i),
    .tdr_shift_i(tdr_shift_i),
    .match_i    (sig == GOLDEN_SIG),
    .rom_addr_o (rom_addr_o),
    .rom_rd_o   (rom_rd_o),
    .seed_o     (seed),
    .absorb_o   (absorb),
    .shift_ok_o (shift_ok),
    .done_o     (done_o),
    .pass_o     (pass_o)
  );

  rom_sig_misr u_misr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .seed_i  (seed),
    .absorb_i(absorb),
    .data_i  (rom_data_i),
    .shift_i (shift_ok),
    .si_i    (tdr_si_i),
    .sig_o   (sig),
    .so_o    (tdr_so_o)
  );

  // R8
  shift_keeps_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdr_shift_i && done_o && test_en_i |=> $stable(pass_o) && done_o);
endmodule

// File: tb/rom_sig_bist_test.sv
`timescale 1ns/1ps
module rom_sig_bist_test;
  localparam int unsigned AW    = 4;
  localparam int unsigned DEPTH = 2 ** AW;

  function automatic logic [31:0] rom_word(input int unsigned a);
    logic [31:0] aa;
    aa = a;
    return (aa * 32'h9E37_79B9) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] sig_step(input logic [31:0] s, input logic [31:0] d);
    logic [31:0] n;
    n = {s[30:0], 1'b0} ^ d;
    if (s[31]) n = n ^ 32'h0040_0007;
    return n;
  endfunction

  function automatic logic [31:0] calc_sig();
    logic [31:0] s;
    s = '1;
    for (int a = 0; a < DEPTH; a++) s = sig_step(s, rom_word(a));
    return s;
  endfunction

  localparam logic [31:0] GOLD = calc_sig();

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, shift = 1'b0, si = 1'b0, corrupt = 1'b0;
  logic [AW-1:0] addr;
  logic rd, so, done, pass;
  logic [31:0] rom_q = '0;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk)
    if (rd) rom_q <= rom_word(int'(addr)) ^ ((corrupt && addr == 5) ? 32'h100 : 32'h0);

  rom_sig_bist #(.ADDR_W(AW), .GOLDEN_SIG(GOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .test_en_i(en), .rom_addr_o(addr), .rom_rd_o(rd),
    .rom_data_i(rom_q), .tdr_shift_i(shift), .tdr_si_i(si), .tdr_so_o(so),
    .done_o(done), .pass_o(pass)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  // start a run from idle; check address stream, latency, result
  task automatic run_test(input bit exp_pass, input string tag);
    int cnt = 0, idx = 0;
    bit addr_ok = 1;
    @(negedge clk); en = 1'b1;
    do begin
      @(negedge clk); cnt++;
      if (rd) begin
        if (addr != AW'(idx)) addr_ok = 0;
        idx++;
      end
    end while (!done && cnt < 4 * DEPTH);
    chk(addr_ok && idx == DEPTH, {"R2 address sequence ", tag}, 32'(idx), 32'(DEPTH));
    chk(cnt == DEPTH + 3, {"R4 done latency ", tag}, 32'(cnt), 32'(DEPTH + 3));
    chk(pass == exp_pass, {"R5 pass result ", tag}, 32'(pass), 32'(exp_pass));
    repeat (3) @(negedge clk);
    chk(done && pass == exp_pass, {"R4 done held ", tag}, {30'd0, done, pass}, {30'd0, 1'b1, exp_pass});
  endtask

  task automatic go_idle();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(!rd && !done && !pass, "R7 R6 idle after enable low", {29'd0, rd, done, pass}, 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk(!done && !pass && !rd, "R1 reset outputs", {29'd0, rd, done, pass}, 32'd0);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !pass && !rd, "R1 after reset release", {29'd0, rd, done, pass}, 32'd0);
  endtask

  // shift out 32 bits while writing pattern; returns read word
  task automatic shift32(input logic [31:0] pat, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      shift = 1'b1; si = pat[i];
      got[i] = so;
    end
    @(negedge clk); shift = 1'b0;
  endtask

  task automatic t_readout();
    logic [31:0] got;
    shift32(32'hA5C3_1E0F, got);
    chk(got == GOLD, "R3 R8 serial signature readout", got, GOLD);
    chk(done && pass, "R8 result kept during shift", {30'd0, done, pass}, 32'd3);
    shift32(32'h0, got);
    chk(got == 32'hA5C3_1E0F, "R8 serial write then read", got, 32'hA5C3_1E0F);
  endtask

  task automatic t_abort();
    @(negedge clk); en = 1'b1;
    repeat (6) @(negedge clk);
    chk(rd, "R2 reading mid run", 32'(rd), 32'd1);
    go_idle();
    run_test(1'b1, "after abort");
  endtask

  task automatic t_shift_in_run();
    @(negedge clk); shift = 1'b1; si = 1'b1;
    run_test(1'b1, "R9 shift held during run");
    @(negedge clk); shift = 1'b0;
  endtask

  initial begin
    t_reset();
    run_test(1'b1, "good rom");
    t_readout();
    go_idle();
    t_abort();
    go_idle();
    t_shift_in_run();
    go_idle();
    corrupt = 1'b1;
    run_test(1'b0, "corrupted word");
    go_idle();
    corrupt = 1'b0;
    run_test(1'b1, "R3 reseed after bad run");
    finish_run();
  end
endmodule